// File: doc/BRIEF.md
# Memory-Attribute Port Router

This block sits between the data-side request source of a processor and its two outbound master ports. A narrow 32-bit port serves private peripherals, and a wide 64-bit port serves the main memory system. Each request carries an address, a transfer size, a write flag with write data, a memory kind, a shareability bit, the kind of requester, and an exclusive flag. The router picks the destination from those attributes alone, with no address decode involved.

Only data-side requests to private (non-shared) device memory are steered to the narrow port. A remap switch turns that class back into shared device memory, so that it also travels on the wide port. The narrow port cannot carry misaligned or exclusive transfers. A request that would go there with either property is refused with a one-cycle error pulse and is not issued. The narrow port allows a single transfer in flight, reads and writes counted together. Requests bound for it are held off through `req_ready` until the port reports completion on `periph_done`. Requests bound for the wide port are never held off.

The decision is combinational. The accepted request is captured in one register stage and presented on the selected port as a one-cycle valid pulse.

Top module: `port_router`

## Requirements
- R1: A request whose source is data (`req_src`=0), whose memory kind is device (`req_mtype`=1) and which is non-shared (`req_shared`=0) goes to the narrow port when `remap_en` is 0, provided it is aligned and not exclusive.
- R2: When `remap_en` is 1, non-shared device data requests go to the wide port and are never refused.
- R3: Instruction fetches (`req_src`=1) and DMA requests (`req_src`=2) always go to the wide port, whatever their memory kind, shareability, alignment or exclusive flag.
- R4: Normal memory (`req_mtype`=0), strongly ordered memory (`req_mtype`=2) and shared device memory go to the wide port.
- R5: A request bound for the narrow port whose address is not a multiple of its size (`req_size` 0/1/2/3 = 1/2/4/8 bytes) produces `err_valid` and no issue on either port.
- R6: An exclusive request (`req_excl`=1) bound for the narrow port produces `err_valid` and no issue on either port.
- R7: Misaligned or exclusive requests bound for the wide port are issued on it unchanged.
- R8: While a narrow-port transfer is in flight, a request bound for the narrow port sees `req_ready`=0 and is not issued. A request bound for the wide port is still accepted.
- R9: `periph_done` ends the in-flight transfer. `req_ready` for a narrow-port request returns to 1 in the cycle after `periph_done` is sampled.
- R10: An accepted request appears one clock later as a single-cycle pulse on exactly one of `main_valid`, `periph_valid` or `err_valid`, with its address, size and write flag.
- R11: After reset, all three valid outputs are 0 and `req_ready` is 1.
- R12: The narrow port's write data is the 32-bit lane of `req_wdata` picked by address bit 2 (bit 2 = 1 selects bits 63:32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Transfer size, log2 bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_mtype | input | 2 | 0 normal, 1 device, 2 strongly ordered |
| req_shared | input | 1 | Shareable attribute |
| req_src | input | 2 | 0 data, 1 instruction fetch, 2 DMA |
| req_excl | input | 1 | Exclusive access |
| remap_en | input | 1 | Treat non-shared device as shared device |
| main_valid | output | 1 | Wide-port issue pulse |
| main_addr | output | 32 | Wide-port address |
| main_size | output | 2 | Wide-port size |
| main_write | output | 1 | Wide-port direction |
| main_wdata | output | 64 | Wide-port write data |
| periph_valid | output | 1 | Narrow-port issue pulse |
| periph_addr | output | 32 | Narrow-port address |
| periph_size | output | 2 | Narrow-port size |
| periph_write | output | 1 | Narrow-port direction |
| periph_wdata | output | 32 | Narrow-port write data lane |
| periph_done | input | 1 | Narrow-port transfer completed |
| err_valid | output | 1 | Refused-request pulse |

## Verification
The embedded assertions check on every cycle the properties that need no knowledge of the intended destination. At most one output pulse is active at a time. The narrow port never issues back to back. Stalls happen only while that port is busy. Every narrow-port issue comes from a data-side request with remap off. Every error has a misaligned or exclusive cause. The actual routing table needs the bench's scenarios: which attribute combination lands on which port, the exact cycle at which `req_ready` returns after completion, and the choice of write-data lane.

// File: rtl/port_router_pkg.sv
package port_router_pkg;

    typedef enum logic [1:0] {
        MK_NORMAL = 2'd0,
        MK_DEVICE = 2'd1,
        MK_STRONG = 2'd2,
        MK_RSVD   = 2'd3
    } mem_kind_e;

    typedef enum logic [1:0] {
        RQ_DATA  = 2'd0,
        RQ_FETCH = 2'd1,
        RQ_DMA   = 2'd2,
        RQ_OTHER = 2'd3
    } req_src_e;

    typedef enum logic [1:0] {
        DST_MAIN   = 2'd0,
        DST_PERIPH = 2'd1,
        DST_REJECT = 2'd2,
        DST_NONE   = 2'd3
    } dest_e;

    typedef struct packed {
        req_src_e  src;
        mem_kind_e kind;
        logic      shared;
        logic      excl;
        logic [1:0] size;
    } req_attr_t;

    // low address bits must be zero below the transfer size
    function automatic logic misaligned(input logic [2:0] lo, input logic [1:0] size);
        logic [2:0] mask;
        mask = 3'((4'd1 << size) - 4'd1);
        return |(lo & mask);
    endfunction

endpackage

// File: rtl/pr_route_decode.sv
module pr_route_decode
    import port_router_pkg::*;
(
    input  req_attr_t  attr,
    input  logic [2:0] addr_lo,
    input  logic       remap_en,
    output dest_e      dest
);
    logic private_dev;
    logic bad_for_narrow;

    always_comb begin
        private_dev    = (attr.src == RQ_DATA) && (attr.kind == MK_DEVICE)
                         && !attr.shared && !remap_en;
        bad_for_narrow = attr.excl || misaligned(addr_lo, attr.size);
        if (!private_dev)
            dest = DST_MAIN;
        else if (bad_for_narrow)
            dest = DST_REJECT;
        else
            dest = DST_PERIPH;
    end
endmodule

// File: rtl/pr_periph_gate.sv
module pr_periph_gate (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic done,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else if (issue)
            busy <= 1'b1;
        else if (done)
            busy <= 1'b0;
    end

    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue |=> busy); // R8
endmodule

// File: rtl/pr_issue_stage.sv
module pr_issue_stage
    import port_router_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAIN_DW   = 64,
    parameter int PERIPH_DW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  dest_e                dest,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           size,
    input  logic                 write,
    input  logic [MAIN_DW-1:0]   wdata,
    output logic                 main_valid,
    output logic                 periph_valid,
    output logic                 err_valid,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [1:0]           size_q,
    output logic                 write_q,
    output logic [MAIN_DW-1:0]   wdata_q,
    output logic [PERIPH_DW-1:0] periph_wdata
);
    localparam int LANES    = MAIN_DW / PERIPH_DW;
    localparam int LANE_LSB = $clog2(PERIPH_DW / 8);
    localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_valid   <= 1'b0;
            periph_valid <= 1'b0;
            err_valid    <= 1'b0;
            addr_q       <= '0;
            size_q       <= '0;
            write_q      <= 1'b0;
            wdata_q      <= '0;
        end else begin
            main_valid   <= accept && (dest == DST_MAIN);
            periph_valid <= accept && (dest == DST_PERIPH);
            err_valid    <= accept && (dest == DST_REJECT);
            if (accept) begin
                addr_q  <= addr;
                size_q  <= size;
                write_q <= write;
                wdata_q <= wdata;
            end
        end
    end

    generate
        if (LANES > 1) begin : g_lane
            logic [LANE_W-1:0] lane;
            assign lane         = addr_q[LANE_LSB +: LANE_W];
            assign periph_wdata = wdata_q[lane*PERIPH_DW +: PERIPH_DW];
        end else begin : g_flat
            assign periph_wdata = wdata_q[PERIPH_DW-1:0];
        end
    endgenerate
endmodule

// File: rtl/port_router.sv
module port_router
    import port_router_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAIN_DW   = 64,
    parameter int PERIPH_DW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic [MAIN_DW-1:0]   req_wdata,
    input  logic [1:0]           req_mtype,
    input  logic                 req_shared,
    input  logic [1:0]           req_src,
    input  logic                 req_excl,
    input  logic                 remap_en,
    output logic                 main_valid,
    output logic [ADDR_W-1:0]    main_addr,
    output logic [1:0]           main_size,
    output logic                 main_write,
    output logic [MAIN_DW-1:0]   main_wdata,
    output logic                 periph_valid,
    output logic [ADDR_W-1:0]    periph_addr,
    output logic [1:0]           periph_size,
    output logic                 periph_write,
    output logic [PERIPH_DW-1:0] periph_wdata,
    input  logic                 periph_done,
    output logic                 err_valid
);
    req_attr_t         attr;
    dest_e             dest;
    logic              busy;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic              write_q;
    logic [MAIN_DW-1:0] wdata_q;

    always_comb begin
        attr.src    = req_src_e'(req_src);
        attr.kind   = mem_kind_e'(req_mtype);
        attr.shared = req_shared;
        attr.excl   = req_excl;
        attr.size   = req_size;
    end

    pr_route_decode u_decode (
        .attr     (attr),
        .addr_lo  (req_addr[2:0]),
        .remap_en (remap_en),
        .dest     (dest)
    );

    assign req_ready = !(busy && (dest == DST_PERIPH));
    assign accept    = req_valid && req_ready;

    pr_periph_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .issue (accept && (dest == DST_PERIPH)),
        .done  (periph_done),
        .busy  (busy)
    );

    pr_issue_stage #(
        .ADDR_W    (ADDR_W),
        .MAIN_DW   (MAIN_DW),
        .PERIPH_DW (PERIPH_DW)
    ) u_issue (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .dest         (dest),
        .addr         (req_addr),
        .size         (req_size),
        .write        (req_write),
        .wdata        (req_wdata),
        .main_valid   (main_valid),
        .periph_valid (periph_valid),
        .err_valid    (err_valid),
        .addr_q       (addr_q),
        .size_q       (size_q),
        .write_q      (write_q),
        .wdata_q      (wdata_q),
        .periph_wdata (periph_wdata)
    );

    assign main_addr    = addr_q;
    assign main_size    = size_q;
    assign main_write   = write_q;
    assign main_wdata   = wdata_q;
    assign periph_addr  = addr_q;
    assign periph_size  = size_q;
    assign periph_write = write_q;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_valid, periph_valid, err_valid})); // R10
    AST_NARROW_SINGLE: assert property (@(posedge clk) disable iff (rst)
        periph_valid |=> !periph_valid); // R8
    AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |-> busy); // R8
    AST_NARROW_DATA_SRC: assert property (@(posedge clk) disable iff (rst)
        periph_valid |-> ($past(req_src) == 2'd0)); // R3
    AST_REMAP_WIDE: assert property (@(posedge clk) disable iff (rst)
        periph_valid |-> !$past(remap_en)); // R2
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ($past(req_excl)
                       || misaligned($past(req_addr[2:0]), $past(req_size)))); // R5 R6
endmodule

// File: tb/port_router_tb_top.sv
module port_router_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic [63:0] req_wdata;
    logic [1:0]  req_mtype;
    logic        req_shared;
    logic [1:0]  req_src;
    logic        req_excl;
    logic        remap_en;
    logic        main_valid;
    logic [31:0] main_addr;
    logic [1:0]  main_size;
    logic        main_write;
    logic [63:0] main_wdata;
    logic        periph_valid;
    logic [31:0] periph_addr;
    logic [1:0]  periph_size;
    logic        periph_write;
    logic [31:0] periph_wdata;
    logic        periph_done;
    logic        err_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    port_router dut_i (.*);

    // {req tag, src, mtype, shared, remap, excl, size, addr low byte, expected: 0 wide 1 narrow 2 error}
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {4'd1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 8'h10, 2'd1}, // R1 word
        {4'd2, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd2, 8'h10, 2'd0}, // R2
        {4'd3, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 8'h10, 2'd0}, // R3 fetch
        {4'd3, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h12, 2'd0}, // R3 dma bad
        {4'd4, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 8'h10, 2'd0}, // R4 normal
        {4'd4, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, 8'h10, 2'd0}, // R4 shared dev
        {4'd4, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 8'h10, 2'd0}, // R4 strong
        {4'd5, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 8'h12, 2'd2}, // R5 word
        {4'd5, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 8'h11, 2'd2}, // R5 half
        {4'd6, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h10, 2'd2}, // R6
        {4'd7, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, 8'h13, 2'd0}, // R7
        {4'd1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h13, 2'd1}, // R1 byte
        {4'd2, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 2'd3, 8'h14, 2'd0}  // R2 with R7
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] src, input logic [1:0] mt, input logic sh,
                         input logic rm, input logic ex, input logic [1:0] sz,
                         input logic [31:0] a, input logic wr, input logic [63:0] wd);
        req_valid  = 1'b1;
        req_src    = src;
        req_mtype  = mt;
        req_shared = sh;
        remap_en   = rm;
        req_excl   = ex;
        req_size   = sz;
        req_addr   = a;
        req_write  = wr;
        req_wdata  = wd;
    endtask

    function automatic logic [1:0] route_now();
        if (main_valid && !periph_valid && !err_valid) return 2'd0;
        if (periph_valid && !main_valid && !err_valid) return 2'd1;
        if (err_valid && !main_valid && !periph_valid) return 2'd2;
        return 2'd3;
    endfunction

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        periph_done = 1'b0;
        drive(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0, 64'h0);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 valids", {61'd0, main_valid, periph_valid, err_valid}, 64'd0);
        chk("R11 ready", {63'd0, req_ready}, 64'd1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            logic [31:0] a;
            string tag;
            v = VEC[i];
            a = 32'h4000_0000 | {24'd0, v[9:2]};
            tag = $sformatf("R%0d vec%0d", v[22:19], i);
            drive(v[18:17], v[16:15], v[14], v[13], v[12], v[11:10], a, 1'b1,
                  64'h1111_2222_3333_4444 + 64'(i));
            @(negedge clk);
            req_valid = 1'b0;
            chk({tag, " route"}, {62'd0, route_now()}, {62'd0, v[1:0]});
            if (v[1:0] == 2'd0) begin
                chk({tag, " addr"}, {32'd0, main_addr}, {32'd0, a});
                chk({tag, " size"}, {62'd0, main_size}, {62'd0, v[11:10]});
            end
            if (v[1:0] == 2'd1) begin
                chk({tag, " addr"}, {32'd0, periph_addr}, {32'd0, a});
                periph_done = 1'b1;
                @(negedge clk);
                periph_done = 1'b0;
            end
            @(negedge clk);
            chk({tag, " R10 pulse ends"}, {61'd0, main_valid, periph_valid, err_valid}, 64'd0);
        end

        // R12 lane select, upper lane
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000_0104, 1'b1, 64'hAAAA_5555_1234_5678);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 upper lane", {32'd0, periph_wdata}, 64'hAAAA_5555);
        chk("R10 narrow write", {63'd0, periph_write}, 64'd1);
        periph_done = 1'b1;
        @(negedge clk);
        periph_done = 1'b0;
        // R12 lower lane
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000_0100, 1'b1, 64'hAAAA_5555_1234_5678);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 lower lane", {32'd0, periph_wdata}, 64'h1234_5678);
        // leave this one in flight: R8 busy window
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000_0200, 1'b0, 64'h0);
        #0;
        chk("R8 narrow held", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        chk("R8 no second issue", {62'd0, periph_valid, err_valid}, 64'd0);
        // wide request while narrow busy
        drive(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 32'h8000_0008, 1'b0, 64'h0);
        #0;
        chk("R8 wide ready", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        chk("R8 wide issued", {63'd0, main_valid}, 64'd1);
        chk("R8 wide addr", {32'd0, main_addr}, 64'h8000_0008);
        // narrow again, completion arrives this cycle
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000_0300, 1'b0, 64'h0);
        periph_done = 1'b1;
        #0;
        chk("R9 still held during done", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        periph_done = 1'b0;
        #0;
        chk("R9 ready after done", {63'd0, req_ready}, 64'd1);
        chk("R9 nothing issued yet", {61'd0, main_valid, periph_valid, err_valid}, 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 narrow issued", {63'd0, periph_valid}, 64'd1);
        chk("R9 narrow addr", {32'd0, periph_addr}, 64'h4000_0300);
        // R6 refusal does not occupy the narrow port
        periph_done = 1'b1;
        @(negedge clk);
        periph_done = 1'b0;
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 32'h4000_0400, 1'b0, 64'h0);
        @(negedge clk);
        chk("R6 refused", {61'd0, main_valid, periph_valid, err_valid}, 64'd1);
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000_0404, 1'b0, 64'h0);
        #0;
        chk("R6 no busy after refusal", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 issue after refusal", {63'd0, periph_valid}, 64'd1);
        periph_done = 1'b1;
        @(negedge clk);
        periph_done = 1'b0;

        // reset mid-flight
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000_0500, 1'b0, 64'h0);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 valids after reset", {61'd0, main_valid, periph_valid, err_valid}, 64'd0);
        drive(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 32'h4000_0600, 1'b0, 64'h0);
        #0;
        chk("R11 busy cleared by reset", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule